// File: doc/BRIEF.md
# Oversampling ADC Conversion Sequencer

This block drives a successive-approximation conversion core. For each conversion it sets the analog multiplexer, holds the sample switch closed for a programmable number of half ADC-clock cycles, and then fires a one-cycle start to the core. It waits for the core's done strobe and takes the 12-bit code that comes with it. The block runs on a clock at twice the ADC clock, so the sample window can be set in half-cycle steps; for example, 39 ticks gives 19.5 ADC cycles. The core's own 12.5-cycle conversion lasts 25 ticks of this clock.

The block steps through a fixed round of three channels: the signal input, a mid-supply offset and an internal reference. All three channels use the same oversampling setting. For each channel it adds 2^k raw codes into a 20-bit accumulator, with k up to 8. It then shifts the sum right by a programmable amount and writes the result into that channel's register, together with a one-cycle valid pulse. If calibration is enabled, the first run after reset begins with one conversion of the zero input. Its code becomes an offset that is subtracted from every later raw code, clamped at zero. Raising `run` starts a round and rounds repeat while it stays high. Once `run` is low when a reference result completes, the block stops and waits idle.

Top module: `os_adc_seq`

## Requirements
- R1: After reset, `smp_en`, `core_start` and `res_valid` are 0, and all three result registers read 0.
- R2: Each sample window holds `smp_en` high for exactly `smp_half` clock cycles; a value of 0 is treated as 1. `core_start` is high for one cycle, in the first cycle after `smp_en` falls, and never while `smp_en` is high.
- R3: `mux_sel` stays constant from the start of a sample window until the core reports done. Its encoding is 0 for the signal channel, 1 for mid-supply, 2 for reference and 3 for the calibration (zero) input.
- R4: Each channel result is built from exactly 2^`os_log2` conversions. Values of `os_log2` above 8 are treated as 8, and the accumulator never exceeds 4095 times the number of conversions summed so far.
- R5: After a channel's last conversion, its register takes the sum shifted right by `res_shift`, clamped to 4095. Bit i of `res_valid` pulses for one cycle in the same cycle that register i changes (bit 0 signal, bit 1 mid, bit 2 reference), and at most one bit is high at a time.
- R6: Channels complete in the order signal, mid-supply, reference and then repeat. If `run` is low when a reference result completes, no further sample window opens.
- R7: With `cal_en` high, the first run after reset performs exactly one conversion with `mux_sel`=3 before any channel conversion. No further calibration conversion happens until the next reset.
- R8: Before accumulation, the stored calibration code is subtracted from every channel code. A negative difference counts as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the ADC clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start rounds; checked when a reference result completes |
| cal_en | input | 1 | Enable the one-time zero calibration |
| smp_half | input | 8 | Sample window length in half ADC cycles |
| os_log2 | input | 4 | Log2 of the number of conversions per result (max 8) |
| res_shift | input | 4 | Right shift applied to the sum |
| mux_sel | output | 2 | Analog input select |
| smp_en | output | 1 | Sample switch closed |
| core_start | output | 1 | One-cycle conversion start to the core |
| core_done | input | 1 | One-cycle conversion complete from the core |
| core_code | input | 12 | Raw code, valid with `core_done` |
| res_sig | output | 12 | Signal channel result |
| res_mid | output | 12 | Mid-supply channel result |
| res_ref | output | 12 | Reference channel result |
| res_valid | output | 3 | Per-channel result update pulse |

## Verification
The block's busiest edge is the one where the last conversion of a channel completes. On that edge the scaled result is written, the valid pulse fires, the accumulator is cleared and the multiplexer moves to the next channel's sample window. The bench provokes this on every conversion by running single-conversion results with a one-tick sample window. It checks both the result value and the length of the window that follows. A second collision, where the offset subtraction clamps at zero inside a long sum, is provoked by giving a channel a level below the calibration code, with a dither that crosses it. The expected totals come from a scoreboard that replays the same code sequence the core model produces.

// File: rtl/os_adc_seq.sv
module os_adc_seq #(
  parameter int CODE_W      = 12,
  parameter int OS_MAX_LOG2 = 8,
  parameter int SMP_W       = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 cal_en,
  input  logic [SMP_W-1:0]     smp_half,
  input  logic [3:0]           os_log2,
  input  logic [3:0]           res_shift,
  output logic [1:0]           mux_sel,
  output logic                 smp_en,
  output logic                 core_start,
  input  logic                 core_done,
  input  logic [CODE_W-1:0]    core_code,
  output logic [CODE_W-1:0]    res_sig,
  output logic [CODE_W-1:0]    res_mid,
  output logic [CODE_W-1:0]    res_ref,
  output logic [2:0]           res_valid
);
  localparam int ACC_W = CODE_W + OS_MAX_LOG2;
  localparam int CNT_W = OS_MAX_LOG2 + 1;
  localparam logic [3:0] OS_LIM = 4'(OS_MAX_LOG2);
  localparam logic [1:0] CAL_SEL = 2'd3;
  localparam logic [1:0] LAST_CH = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_CONV} st_t;

  st_t               st;
  logic [1:0]        ch;
  logic [SMP_W-1:0]  scnt;
  logic [CNT_W-1:0]  ncnt;
  logic [ACC_W-1:0]  acc;
  logic [CODE_W-1:0] offs;
  logic              cal_done, start_q;
  logic [2:0]        vld_q;

  wire [3:0]        os_eff    = (os_log2 > OS_LIM) ? OS_LIM : os_log2;
  wire [CNT_W-1:0]  n_target  = CNT_W'(1) << os_eff;
  wire [SMP_W-1:0]  smp_len   = (smp_half == '0) ? SMP_W'(1) : smp_half;
  wire              smp_last  = scnt >= (smp_len - SMP_W'(1));
  wire [CODE_W:0]   diff      = {1'b0, core_code} - {1'b0, offs};
  wire [CODE_W-1:0] adj       = diff[CODE_W] ? '0 : diff[CODE_W-1:0];
  wire [ACC_W-1:0]  acc_nx    = acc + ACC_W'(adj);
  wire [ACC_W-1:0]  scaled    = acc_nx >> res_shift;
  wire [CODE_W-1:0] res_nx    = (|scaled[ACC_W-1:CODE_W]) ? '1 : scaled[CODE_W-1:0];
  wire              last_conv = (ncnt + CNT_W'(1)) == n_target;

  assign mux_sel    = ch;
  assign smp_en     = (st == S_SAMP);
  assign core_start = start_q;
  assign res_valid  = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ch       <= '0;
      scnt     <= '0;
      ncnt     <= '0;
      acc      <= '0;
      offs     <= '0;
      cal_done <= 1'b0;
      start_q  <= 1'b0;
      vld_q    <= '0;
      res_sig  <= '0;
      res_mid  <= '0;
      res_ref  <= '0;
    end else begin
      start_q <= 1'b0;
      vld_q   <= '0;
      case (st)
        S_IDLE: if (run) begin
          ch   <= (cal_en && !cal_done) ? CAL_SEL : 2'd0;
          scnt <= '0;
          ncnt <= '0;
          acc  <= '0;
          st   <= S_SAMP;
        end
        S_SAMP: begin
          if (smp_last) begin
            st      <= S_CONV;
            start_q <= 1'b1;
            scnt    <= '0;
          end else begin
            scnt <= scnt + SMP_W'(1);
          end
        end
        S_CONV: if (core_done) begin
          st <= S_SAMP;
          if (ch == CAL_SEL) begin
            offs     <= core_code;
            cal_done <= 1'b1;
            ch       <= 2'd0;
          end else if (last_conv) begin
            acc       <= '0;
            ncnt      <= '0;
            vld_q[ch] <= 1'b1;
            case (ch)
              2'd0:    res_sig <= res_nx;
              2'd1:    res_mid <= res_nx;
              default: res_ref <= res_nx;
            endcase
            if (ch == LAST_CH) begin
              ch <= 2'd0;
              if (!run) st <= S_IDLE;
            end else begin
              ch <= ch + 2'd1;
            end
          end else begin
            acc  <= acc_nx;
            ncnt <= ncnt + CNT_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_START_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(smp_en) |-> core_start); // R2
  AST_START_NOT_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !smp_en); // R2
  AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV) |-> $stable(mux_sel)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= ACC_W'(ncnt) * ACC_W'((1 << CODE_W) - 1)); // R4
  AST_ONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_valid)); // R5
  AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (|res_valid) |-> $past(core_done)); // R5
  AST_CAL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (mux_sel != CAL_SEL)); // R7
endmodule

// File: tb/os_adc_seq_test.sv
module os_adc_seq_test;
  localparam int CALV = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cal_en = 1'b0;
  logic [7:0]  smp_half = 8'd1;
  logic [3:0]  os_log2 = 4'd0;
  logic [3:0]  res_shift = 4'd0;
  logic [1:0]  mux_sel;
  logic        smp_en, core_start;
  logic        core_done = 1'b0;
  logic [11:0] core_code = '0;
  logic [11:0] res_sig, res_mid, res_ref;
  logic [2:0]  res_valid;

  int checks = 0;
  int fails = 0;
  int q_ch[$];
  int q_val[$];
  int base[3];
  int mcnt[3];
  int ecnt[3];
  int cal_calls = 0;
  int exp_len = 1;
  int cur_len = 0;
  bit mbusy = 0;
  int mtmr = 0;
  int mval = 0;

  os_adc_seq uut (
    .clk(clk), .rst_n(rst_n), .run(run), .cal_en(cal_en), .smp_half(smp_half),
    .os_log2(os_log2), .res_shift(res_shift), .mux_sel(mux_sel), .smp_en(smp_en),
    .core_start(core_start), .core_done(core_done), .core_code(core_code),
    .res_sig(res_sig), .res_mid(res_mid), .res_ref(res_ref), .res_valid(res_valid)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_code(input int sel);
    int v;
    if (sel == 3) begin
      cal_calls++;
      return (cal_calls == 1) ? CALV : CALV + 20;
    end
    v = base[sel] + (mcnt[sel] % 4);
    mcnt[sel]++;
    return (v > 4095) ? 4095 : v;
  endfunction

  always @(negedge clk) begin
    core_done = 1'b0;
    if (mbusy) begin
      if (mtmr == 24) begin
        core_done = 1'b1;
        core_code = 12'(mval);
        mbusy = 0;
      end else mtmr++;
    end
    if (core_start) begin
      mbusy = 1;
      mtmr = 0;
      mval = model_code(int'(mux_sel));
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (smp_en) cur_len++;
      else if (cur_len > 0) begin
        check(cur_len == exp_len, "R2 window length", cur_len, exp_len);
        check(core_start == 1'b1, "R2 start after window", int'(core_start), 1);
        cur_len = 0;
      end
      for (int c = 0; c < 3; c++) begin
        if (res_valid[c]) begin
          int act;
          act = (c == 0) ? int'(res_sig) : (c == 1) ? int'(res_mid) : int'(res_ref);
          if (q_ch.size() == 0) begin
            check(1'b0, "R6 unexpected result", c, -1);
          end else begin
            int ec, ev;
            ec = q_ch.pop_front();
            ev = q_val.pop_front();
            check(ec == c, "R6 channel order", c, ec);
            check(act == ev, "R4 R5 R8 result value", act, ev);
          end
        end
      end
    end
  end

  function automatic int expect_val(input int c, input int n, input int sh);
    longint sum = 0;
    longint r;
    for (int i = 0; i < n; i++) begin
      int raw;
      raw = base[c] + ((ecnt[c] + i) % 4);
      if (raw > 4095) raw = 4095;
      sum += (raw > CALV) ? raw - CALV : 0;
    end
    ecnt[c] += n;
    r = sum >> sh;
    return (r > 4095) ? 4095 : int'(r);
  endfunction

  task automatic do_round(input int smp, input int os, input int sh,
                          input int b0, input int b1, input int b2);
    int n;
    @(posedge clk); #1;
    smp_half = 8'(smp);
    os_log2 = 4'(os);
    res_shift = 4'(sh);
    base[0] = b0; base[1] = b1; base[2] = b2;
    exp_len = (smp == 0) ? 1 : smp;
    n = 1 << ((os > 8) ? 8 : os);
    for (int c = 0; c < 3; c++) begin
      q_ch.push_back(c);
      q_val.push_back(expect_val(c, n, sh));
    end
    run = 1'b1;
    do @(negedge clk); while (!res_valid[0]);
    run = 1'b0;
    while (q_ch.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    check(smp_en == 1'b0 && !mbusy, "R6 stop after round", int'(smp_en), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(smp_en == 1'b0, "R1 smp_en reset", int'(smp_en), 0);
    check(core_start == 1'b0, "R1 core_start reset", int'(core_start), 0);
    check(res_valid == 3'b0, "R1 valid reset", int'(res_valid), 0);
    check(res_sig == 0 && res_mid == 0 && res_ref == 0, "R1 results reset",
          int'(res_sig) + int'(res_mid) + int'(res_ref), 0);
    rst_n = 1'b1;
    cal_en = 1'b1;
    do_round(39, 8, 8, 2000, 1650, 1480);
    check(cal_calls == 1, "R7 one calibration", cal_calls, 1);
    do_round(1, 2, 0, 4000, 100, 3);
    do_round(0, 0, 0, 1000, 2, 50);
    do_round(5, 12, 10, 4095, 0, 2047);
    check(cal_calls == 1, "R7 no recalibration", cal_calls, 1);
    check(mcnt[0] == ecnt[0], "R4 conversion count", mcnt[0], ecnt[0]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule